// File: doc/BRIEF.md
# Toggle-Triggered Scan Cell Array

A test-access register of `N_CELLS` cells. Every cell pairs a data flip-flop, whose value drives the functional logic, with a trigger flip-flop. The trigger flip-flops are linked into one serial chain. A two-bit mode input selects one of three behaviours. Shift mode moves trigger data along the chain and leaves the data flip-flops alone. Trigger mode inverts selected data bits in a single clock. Normal mode makes each cell a plain enabled register.

During test, a new stimulus vector is not loaded bit by bit. Each cell compares its own trigger bit with the trigger bit of the cell to its left. In one trigger cycle, every data bit inverts where the two differ. The leftmost cell uses the serial input as its left neighbour. A tester shifts a difference pattern into the chain and then applies it with a single update cycle. When Normal mode is entered, the chain is seeded once with an alternating pattern.

Top module: `tta_scan_array`

## Requirements
- R1: While reset is asserted and right after it is released, every data bit is 0 and the serial output is 0 (all trigger bits are 0).
- R2: With mode code 2'b01 (Shift), each clock moves trigger bit i to cell i+1 and takes the serial input into cell 0. The data vector keeps its value whatever the enable and functional inputs are.
- R3: The unused mode code 2'b11 behaves exactly like Shift.
- R4: With mode code 2'b10 (Trigger), each clock inverts data bit i when trigger bit i differs from its left neighbour, and keeps it otherwise. The left neighbour of cell 0 is the serial input of that cycle. Trigger bits hold, and the enable and functional inputs have no effect.
- R5: On the first clock with mode code 2'b00 (Normal) after reset or after any other mode, trigger bit i becomes 1 for even i and 0 for odd i. Trigger bits then hold for as long as Normal continues.
- R6: In Normal mode, a clock with enable high loads the functional input vector into the data bits, and a clock with enable low keeps them.
- R7: The serial output always shows the trigger bit of the last cell (index N_CELLS-1).
- R8: Two Trigger clocks in a row with an unchanged serial input return the data vector to its value from before the first of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 Normal, 01 Shift, 10 Trigger, 11 acts as Shift |
| en | input | 1 | Load enable for Normal mode |
| si | input | 1 | Serial trigger input; left neighbour of cell 0 |
| func_d | input | N_CELLS | Functional data input vector |
| so | output | 1 | Serial trigger output (last cell) |
| dr_q | output | N_CELLS | Data flip-flop vector |

## Verification
The trigger bits cannot be seen directly. The Normal-entry seed is therefore the hardest state to confirm from the ports. The stimulus enters Normal, then switches to Trigger. The seeded pattern then shows up as a full inversion of the data vector, with cell 0 set by the serial input. The stimulus also shifts the chain out so that each seeded bit appears on the serial output. Mode changes are also driven at random against a behavioural model, so that every transition between modes, including the unused code, reaches a Normal entry.

// File: rtl/tta_pkg.sv
package tta_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL  = 2'b00,
      MODE_SHIFT   = 2'b01,
      MODE_TRIGGER = 2'b10,
      MODE_SPARE   = 2'b11
   } tta_mode_e;

   typedef enum logic [1:0] {
      OP_CHAIN  = 2'b00,
      OP_TOGGLE = 2'b01,
      OP_FUNC   = 2'b10
   } tta_op_e;

   function automatic logic seed_bit(input int unsigned idx);
      return (idx % 2 == 0) ? 1'b1 : 1'b0;
   endfunction

endpackage

// File: rtl/tta_mode_ctl.sv
module tta_mode_ctl
   import tta_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   output tta_op_e    op,
   output logic       seed
);

   logic in_func_q;

   always_comb begin
      unique case (mode)
         MODE_NORMAL:  op = OP_FUNC;
         MODE_TRIGGER: op = OP_TOGGLE;
         default:      op = OP_CHAIN;
      endcase
   end

   assign seed = (op == OP_FUNC) && !in_func_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_func_q <= 1'b0;
      else        in_func_q <= (op == OP_FUNC);
   end

endmodule

// File: rtl/tta_cell.sv
module tta_cell
   import tta_pkg::*;
#(
   parameter int unsigned IDX = 0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  tta_op_e op,
   input  logic    seed,
   input  logic    en,
   input  logic    tr_left,
   input  logic    func_d,
   output logic    tr_q,
   output logic    dr_q
);

   localparam logic SEED_VAL = seed_bit(IDX);

   logic tr_next;
   logic dr_next;
   logic flip;

   assign flip = tr_q ^ tr_left;

   always_comb begin
      tr_next = tr_q;
      dr_next = dr_q;
      unique case (op)
         OP_CHAIN:  tr_next = tr_left;
         OP_TOGGLE: dr_next = dr_q ^ flip;
         OP_FUNC: begin
            if (seed) tr_next = SEED_VAL;
            if (en)   dr_next = func_d;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tr_q <= 1'b0;
         dr_q <= 1'b0;
      end else begin
         tr_q <= tr_next;
         dr_q <= dr_next;
      end
   end

endmodule

// File: rtl/tta_scan_array.sv
module tta_scan_array
   import tta_pkg::*;
#(
   parameter int unsigned N_CELLS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mode,
   input  logic               en,
   input  logic               si,
   input  logic [N_CELLS-1:0] func_d,
   output logic               so,
   output logic [N_CELLS-1:0] dr_q
);

   localparam int unsigned LAST = N_CELLS - 1;

   initial begin
      assert (N_CELLS >= 2)
         else $error("tta_scan_array: N_CELLS must be at least 2");
   end

   tta_op_e            op;
   logic               seed;
   logic [N_CELLS-1:0] tr_vec;
   logic [N_CELLS-1:0] left_vec;

   tta_mode_ctl u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .op    (op),
      .seed  (seed)
   );

   for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
      if (g == 0) begin : g_edge
         assign left_vec[g] = si;
      end else begin : g_inner
         assign left_vec[g] = tr_vec[g-1];
      end

      tta_cell #(.IDX(g)) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .op      (op),
         .seed    (seed),
         .en      (en),
         .tr_left (left_vec[g]),
         .func_d  (func_d[g]),
         .tr_q    (tr_vec[g]),
         .dr_q    (dr_q[g])
      );
   end

   assign so = tr_vec[LAST];

endmodule

// File: rtl/tta_scan_array_chk.sv
module tta_scan_array_chk #(
   parameter int unsigned N_CELLS = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         mode,
   input logic               en,
   input logic               si,
   input logic [N_CELLS-1:0] func_d,
   input logic               so,
   input logic [N_CELLS-1:0] dr_q,
   input logic [N_CELLS-1:0] tr_q
);

   logic               was_func_q;
   logic [N_CELLS-1:0] seed_pat;
   logic [N_CELLS-1:0] nbr;
   logic               shifting;

   for (genvar g = 0; g < N_CELLS; g++) begin : g_pat
      assign seed_pat[g] = (g % 2 == 0);
      if (g == 0) begin : g_e
         assign nbr[g] = si;
      end else begin : g_i
         assign nbr[g] = tr_q[g-1];
      end
   end

   assign shifting = (mode == 2'b01) || (mode == 2'b11);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) was_func_q <= 1'b0;
      else        was_func_q <= (mode == 2'b00);
   end

   AST_SHIFT_DR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      shifting |=> $stable(dr_q)); // R2

   AST_SHIFT_CHAIN_IN: assert property (@(posedge clk) disable iff (!rst_n)
      shifting |=> (tr_q[0] == $past(si))); // R3

   AST_SHIFT_SO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      shifting |=> (so == $past(tr_q[N_CELLS-2]))); // R7

   AST_TRIG_TR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |=> $stable(tr_q)); // R4

   AST_TRIG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10) |=> ((dr_q ^ $past(dr_q)) == $past(tr_q ^ nbr))); // R4

   AST_NORM_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == 2'b00) && !was_func_q) |=> (tr_q == seed_pat)); // R5

   AST_NORM_TR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == 2'b00) && was_func_q) |=> $stable(tr_q)); // R5

   AST_NORM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == 2'b00) && en) |=> (dr_q == $past(func_d))); // R6

   AST_NORM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == 2'b00) && !en) |=> $stable(dr_q)); // R6

endmodule

bind tta_scan_array tta_scan_array_chk #(.N_CELLS(N_CELLS)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .mode   (mode),
   .en     (en),
   .si     (si),
   .func_d (func_d),
   .so     (so),
   .dr_q   (dr_q),
   .tr_q   (tr_vec)
);

// File: tb/tta_scan_array_tb.sv
module tta_scan_array_tb;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode = 2'b01;
   logic         en = 1'b0;
   logic         si = 1'b0;
   logic [N-1:0] func_d = '0;
   logic         so;
   logic [N-1:0] dr_q;

   int runs  = 0;
   int fails = 0;
   bit done  = 1'b0;

   bit m_tr [N];
   bit m_dr [N];
   bit m_was_norm;
   logic [N-1:0] snap;
   int unsigned lcg = 32'h1234_5678;

   always #4 clk = ~clk;

   tta_scan_array #(.N_CELLS(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .en(en), .si(si),
      .func_d(func_d), .so(so), .dr_q(dr_q)
   );

   function automatic logic [N-1:0] model_dr();
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = m_dr[i];
      return v;
   endfunction

   task automatic check_dr(string tag, logic [N-1:0] exp);
      runs++;
      if (dr_q !== exp) begin
         fails++;
         $display("FAIL %s dr_q actual=%b expected=%b", tag, dr_q, exp);
      end
   endtask

   task automatic check_so(string tag, logic exp);
      runs++;
      if (so !== exp) begin
         fails++;
         $display("FAIL %s so actual=%b expected=%b", tag, so, exp);
      end
   endtask

   task automatic model_clock();
      bit ntr [N];
      bit ndr [N];
      for (int i = 0; i < N; i++) begin
         bit left;
         left = (i == 0) ? si : m_tr[i-1];
         ntr[i] = m_tr[i];
         ndr[i] = m_dr[i];
         if (mode == 2'b10) begin
            if (m_tr[i] != left) ndr[i] = !m_dr[i];
         end else if (mode == 2'b00) begin
            if (!m_was_norm) ntr[i] = (i % 2 == 0);
            if (en) ndr[i] = func_d[i];
         end else begin
            ntr[i] = left;
         end
      end
      m_was_norm = (mode == 2'b00);
      m_tr = ntr;
      m_dr = ndr;
   endtask

   task automatic step(logic [1:0] m, logic e, logic s, logic [N-1:0] d);
      string tag;
      bit entry;
      entry = (m == 2'b00) && !m_was_norm;
      mode = m; en = e; si = s; func_d = d;
      @(posedge clk);
      model_clock();
      @(negedge clk);
      case (m)
         2'b01:   tag = "R2";
         2'b11:   tag = "R3";
         2'b10:   tag = "R4";
         default: tag = entry ? "R5" : "R6";
      endcase
      check_dr(tag, model_dr());
      check_so((m == 2'b00) ? "R5/R7" : "R7", m_tr[N-1]);
   endtask

   function automatic int unsigned next_rand();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return lcg;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", runs, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_tr[i] = 0; m_dr[i] = 0; end
      m_was_norm = 0;
      repeat (3) @(negedge clk);
      check_dr("R1", '0);
      check_so("R1", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_dr("R1", '0);
      check_so("R1", 1'b0);

      // R2: shift a pattern in with enable and data active; data must hold
      for (int i = 0; i < N; i++) step(2'b01, 1'b1, (i % 3 == 0), 8'hFF);
      // R4: one update cycle
      step(2'b10, 1'b1, 1'b0, 8'hAA);
      // R8: second identical update restores the vector
      snap = dr_q;
      step(2'b10, 1'b0, 1'b1, 8'h00);
      step(2'b10, 1'b0, 1'b1, 8'h00);
      check_dr("R8", snap);
      // R3: spare code shifts
      for (int i = 0; i < 3; i++) step(2'b11, 1'b1, 1'b1, 8'h5A);
      // R5/R6: Normal entry with load, then hold
      step(2'b00, 1'b1, 1'b0, 8'hC3);
      check_dr("R6", 8'hC3);
      step(2'b00, 1'b0, 1'b1, 8'h3C);
      check_dr("R6", 8'hC3);
      // R5: seed made visible by an update cycle (si=0 so cell 0 flips too)
      step(2'b10, 1'b0, 1'b0, 8'h00);
      check_dr("R5", ~8'hC3);
      // R5/R7: shift the seed out through so
      for (int i = 0; i < N; i++) begin
         logic expb;
         expb = ((N - 1 - i) % 2 == 0);
         check_so("R7", expb);
         step(2'b01, 1'b0, 1'b0, 8'h00);
      end
      // random mix of modes
      for (int k = 0; k < 800; k++) begin
         int unsigned r;
         r = next_rand();
         step(r[17:16], r[20], r[23], r[31:24]);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
   end

endmodule